// File: doc/BRIEF.md
# Memory Controller Configuration Register Block

This block holds the software-visible configuration and status registers of an ECC memory controller. Software reaches it over a simple word-addressed register bus: one byte address, a write enable, 32-bit write data and 32-bit read data returned in the same cycle. It drives one interrupt line, which a fault-capture strobe from the controller raises and a software write to the fault status register drops.

One elaboration parameter picks one of three implementation variants. The variant fixes an implementation code in the top nibble of the enable register, the mask applied when software writes that register, and which enable bits survive a warm reset. Only variant 0 also decodes a small byte-wide diagnostic store. Two resets come in. A power-on reset loads every register, including the implementation code. A warm reset clears most state but keeps a variant-specific subset of the enable register.

Register map, with the byte address bit 12 clear and the index taken from address bits 11:2: index 0 is enable, 1 is refresh delay, 2 is fault status, 3 is video configuration. With bit 12 set, the low bits address the diagnostic bytes.

Top module: `mc_cfg_regs`

## Requirements
- R1: After power-on reset the block reads as follows. Enable reads as the implementation code: 0x00000000 for variant 0, 0x10000000 for variant 1, 0x20000000 for variant 2. Delay reads 0x20, fault status and video configuration read 0, and the interrupt is low. Address bits 1:0 do not affect register selection.
- R2: On variant 0, a write to enable stores only the data bits under 0x00000103, so bits 31:28 read zero.
- R3: On variants 1 and 2, a write to enable stores the implementation code ORed with the data under 0x00000BFF.
- R4: On variant 0, a warm reset keeps only bit 8 of enable and clears every other bit.
- R5: On variants 1 and 2, a warm reset keeps enable bits 31:24, bits 9:2 and bit 11, and clears bits 1:0 and bit 10.
- R6: A warm reset sets delay to 0x20, clears fault status and video configuration, and drops the interrupt at once.
- R7: Delay (index 1) and video configuration (index 3) store and return all 32 written bits.
- R8: A one-cycle fault strobe loads the fault status word and sets the interrupt from the next clock edge. The interrupt then stays high until software writes fault status.
- R9: A write to fault status stores the data and clears the interrupt. If a fault strobe comes in the same cycle, the strobe wins: the captured word is stored and the interrupt stays high.
- R10: Register indexes 4 and above read as zero, and writes to them change no register.
- R11: On variant 0, byte address 0x1000+n for n below 16 holds a byte. A write stores write data bits 7:0, and a read returns that byte zero-extended. Offsets of 16 and above read as zero.
- R12: On variants 1 and 2, every address with bit 12 set reads zero, and writes there change no register.
- R13: Read data follows the address combinationally, in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| rst_ni | input | 1 | Warm reset, active low, asynchronous |
| addr_i | input | 13 | Byte address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| fault_stb_i | input | 1 | Fault capture strobe |
| fault_status_i | input | 32 | Fault status word captured on the strobe |
| irq_o | output | 1 | Fault interrupt |

## Verification
The hardest case is a fault strobe in the same cycle as a software write to fault status. The bench drives both on one edge with different data words, then reads which word was stored and whether the interrupt stayed up. The warm-reset retention rules need a register that holds all ones before reset, so the bench saturates enable first and then pulses only the warm reset. All three variants are instantiated side by side on shared stimulus, which gives every sweep a per-variant expectation.

// File: rtl/mc_cfg_pkg.sv
package mc_cfg_pkg;
  localparam int unsigned DW = 32;

  localparam logic [DW-1:0] EN_WMASK_V0  = 32'h0000_0103;
  localparam logic [DW-1:0] EN_WMASK_V12 = 32'h0000_0BFF;
  localparam logic [DW-1:0] EN_KEEP_V0   = 32'h0000_0100;
  localparam logic [DW-1:0] EN_KEEP_V12  = 32'hFF00_0BFC;
  localparam logic [DW-1:0] DLY_RST      = 32'h0000_0020;

  typedef enum logic [1:0] {
    IDX_EN  = 2'd0,
    IDX_DLY = 2'd1,
    IDX_FSR = 2'd2,
    IDX_VCR = 2'd3
  } reg_idx_e;

  function automatic logic [DW-1:0] impl_code(int unsigned v);
    return {4'(v), 28'h0};
  endfunction

  function automatic logic [DW-1:0] en_wmask(int unsigned v);
    return (v == 0) ? EN_WMASK_V0 : EN_WMASK_V12;
  endfunction

  function automatic logic [DW-1:0] en_keep(int unsigned v);
    return (v == 0) ? EN_KEEP_V0 : EN_KEEP_V12;
  endfunction

  // value stored on a software write to the enable register
  function automatic logic [DW-1:0] en_store(int unsigned v, logic [DW-1:0] d);
    return (v == 0) ? (d & EN_WMASK_V0) : (impl_code(v) | (d & EN_WMASK_V12));
  endfunction
endpackage

// File: rtl/mc_cfg_decode.sv
module mc_cfg_decode #(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned DIAG_DEPTH = 16,
  parameter bit          DIAG_EN    = 1'b1,
  localparam int unsigned DIAG_AW   = $clog2(DIAG_DEPTH)
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               sel_en_o,
  output logic               sel_dly_o,
  output logic               sel_fsr_o,
  output logic               sel_vcr_o,
  output logic               sel_diag_o,
  output logic [DIAG_AW-1:0] diag_idx_o
);
  import mc_cfg_pkg::*;

  localparam int unsigned IDX_W = ADDR_W - 3;
  localparam logic [ADDR_W-2:0] DIAG_LIM = (ADDR_W-1)'(DIAG_DEPTH);

  logic              in_win;
  logic [ADDR_W-2:0] offset;
  logic [IDX_W-1:0]  idx;

  assign in_win = addr_i[ADDR_W-1];
  assign offset = addr_i[ADDR_W-2:0];
  assign idx    = offset[ADDR_W-2:2];

  assign sel_en_o   = !in_win && (idx == IDX_W'(IDX_EN));
  assign sel_dly_o  = !in_win && (idx == IDX_W'(IDX_DLY));
  assign sel_fsr_o  = !in_win && (idx == IDX_W'(IDX_FSR));
  assign sel_vcr_o  = !in_win && (idx == IDX_W'(IDX_VCR));
  assign sel_diag_o = DIAG_EN && in_win && (offset < DIAG_LIM);
  assign diag_idx_o = offset[DIAG_AW-1:0];
endmodule

// File: rtl/mc_cfg_enable.sv
module mc_cfg_enable #(
  parameter int unsigned VARIANT = 0
) (
  input  logic        clk_i,
  input  logic        por_ni,
  input  logic        warm_rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] en_o
);
  import mc_cfg_pkg::*;

  localparam logic [31:0] KEEP = en_keep(VARIANT);
  localparam logic [31:0] POR  = impl_code(VARIANT);

  logic [31:0] store;
  logic [31:0] keep_q;
  logic [31:0] clr_q;

  assign store = en_store(VARIANT, wdata_i);

  // bits that survive a warm reset: power-on only
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)   keep_q <= POR & KEEP;
    else if (we_i) keep_q <= store & KEEP;
  end

  // bits cleared by either reset
  always_ff @(posedge clk_i or negedge warm_rst_ni) begin
    if (!warm_rst_ni) clr_q <= POR & ~KEEP;
    else if (we_i)    clr_q <= store & ~KEEP;
  end

  assign en_o = keep_q | clr_q;
endmodule

// File: rtl/mc_cfg_diag.sv
module mc_cfg_diag #(
  parameter int unsigned DEPTH  = 16,
  parameter bit          ENABLE = 1'b1,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          por_ni,
  input  logic          we_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] idx_i,
  output logic [7:0]    rd_o
);
  if (ENABLE) begin : g_store
    logic [7:0] mem_q [DEPTH];
    always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we_i) begin
        mem_q[idx_i] <= wdata_i;
      end
    end
    assign rd_o = mem_q[idx_i];
  end else begin : g_none
    logic unused_in;
    assign unused_in = ^{clk_i, por_ni, we_i, wdata_i, idx_i};
    assign rd_o = '0;
  end
endmodule

// File: rtl/mc_cfg_regs.sv
module mc_cfg_regs #(
  parameter int unsigned VARIANT    = 0,
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned DIAG_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              fault_stb_i,
  input  logic [31:0]       fault_status_i,
  output logic              irq_o
);
  import mc_cfg_pkg::*;

  localparam bit          DIAG_EN = (VARIANT == 0);
  localparam int unsigned DIAG_AW = $clog2(DIAG_DEPTH);

  logic               any_rst_n;
  logic               sel_en, sel_dly, sel_fsr, sel_vcr, sel_diag;
  logic [DIAG_AW-1:0] diag_idx;
  logic [31:0]        en_val;
  logic [31:0]        dly_q, fsr_q, vcr_q;
  logic               irq_q;
  logic [7:0]         diag_rd;

  assign any_rst_n = por_ni & rst_ni;

  mc_cfg_decode #(
    .ADDR_W    (ADDR_W),
    .DIAG_DEPTH(DIAG_DEPTH),
    .DIAG_EN   (DIAG_EN)
  ) u_decode (
    .addr_i    (addr_i),
    .sel_en_o  (sel_en),
    .sel_dly_o (sel_dly),
    .sel_fsr_o (sel_fsr),
    .sel_vcr_o (sel_vcr),
    .sel_diag_o(sel_diag),
    .diag_idx_o(diag_idx)
  );

  mc_cfg_enable #(.VARIANT(VARIANT)) u_enable (
    .clk_i      (clk_i),
    .por_ni     (por_ni),
    .warm_rst_ni(any_rst_n),
    .we_i       (wr_en_i && sel_en),
    .wdata_i    (wdata_i),
    .en_o       (en_val)
  );

  mc_cfg_diag #(.DEPTH(DIAG_DEPTH), .ENABLE(DIAG_EN)) u_diag (
    .clk_i  (clk_i),
    .por_ni (por_ni),
    .we_i   (wr_en_i && sel_diag),
    .wdata_i(wdata_i[7:0]),
    .idx_i  (diag_idx),
    .rd_o   (diag_rd)
  );

  always_ff @(posedge clk_i or negedge any_rst_n) begin
    if (!any_rst_n) begin
      dly_q <= DLY_RST;
      vcr_q <= '0;
    end else if (wr_en_i) begin
      if (sel_dly) dly_q <= wdata_i;
      if (sel_vcr) vcr_q <= wdata_i;
    end
  end

  // hardware capture has priority over a software clear
  always_ff @(posedge clk_i or negedge any_rst_n) begin
    if (!any_rst_n) begin
      fsr_q <= '0;
      irq_q <= 1'b0;
    end else if (fault_stb_i) begin
      fsr_q <= fault_status_i;
      irq_q <= 1'b1;
    end else if (wr_en_i && sel_fsr) begin
      fsr_q <= wdata_i;
      irq_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_en)   rdata_o = en_val;
    if (sel_dly)  rdata_o = dly_q;
    if (sel_fsr)  rdata_o = fsr_q;
    if (sel_vcr)  rdata_o = vcr_q;
    if (sel_diag) rdata_o = {24'h0, diag_rd};
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/mc_cfg_regs_chk.sv
module mc_cfg_regs_chk #(
  parameter int unsigned VARIANT    = 0,
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned DIAG_DEPTH = 16
) (
  input logic              clk_i,
  input logic              por_ni,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [31:0]       wdata_i,
  input logic              fault_stb_i,
  input logic              irq_o,
  input logic [31:0]       rdata_o,
  input logic [31:0]       en_val_i
);
  import mc_cfg_pkg::*;

  localparam int unsigned IDX_W = ADDR_W - 3;

  logic             in_win;
  logic [IDX_W-1:0] idx;
  logic [31:0]      exp_store;
  logic             unused_lo;

  assign in_win    = addr_i[ADDR_W-1];
  assign idx       = addr_i[ADDR_W-2:2];
  assign exp_store = en_store(VARIANT, wdata_i);
  assign unused_lo = ^{addr_i[1:0], DIAG_DEPTH[0]};

  p_en_store_r2_r3: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (wr_en_i && !in_win && idx == '0) |=> (en_val_i == $past(exp_store)));

  p_impl_code_r3: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (!in_win && idx == '0) |-> (rdata_o[31:28] == 4'(VARIANT)));

  p_irq_set_r8: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    fault_stb_i |=> irq_o);

  p_irq_rise_r8: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    $rose(irq_o) |-> $past(fault_stb_i));

  p_irq_clr_r9: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (wr_en_i && !in_win && idx == IDX_W'(2) && !fault_stb_i) |=> !irq_o);

  p_undef_zero_r10: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (!in_win && idx > IDX_W'(3)) |-> (rdata_o == '0));

  p_diag_absent_r12: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (VARIANT != 0 && in_win) |-> (rdata_o == '0));
endmodule

bind mc_cfg_regs mc_cfg_regs_chk #(
  .VARIANT   (VARIANT),
  .ADDR_W    (ADDR_W),
  .DIAG_DEPTH(DIAG_DEPTH)
) u_chk (
  .clk_i      (clk_i),
  .por_ni     (por_ni),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_en_i    (wr_en_i),
  .wdata_i    (wdata_i),
  .fault_stb_i(fault_stb_i),
  .irq_o      (irq_o),
  .rdata_o    (rdata_o),
  .en_val_i   (en_val)
);

// File: tb/mc_cfg_regs_tb.sv
`timescale 1ns/100ps
module mc_cfg_regs_tb;
  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          por_n, rst_n;
  logic [AW-1:0] addr;
  logic          we;
  logic [31:0]   wd;
  logic          stb;
  logic [31:0]   fstat;
  logic [31:0]   rd [3];
  logic          irq [3];
  int            n_tests = 0;
  int            n_fail  = 0;
  bit            done    = 1'b0;

  always #2.5 clk = ~clk;

  mc_cfg_regs #(.VARIANT(0)) u_dut (
    .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we),
    .wdata_i(wd), .rdata_o(rd[0]), .fault_stb_i(stb), .fault_status_i(fstat), .irq_o(irq[0]));
  mc_cfg_regs #(.VARIANT(1)) u_dut_v1 (
    .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we),
    .wdata_i(wd), .rdata_o(rd[1]), .fault_stb_i(stb), .fault_status_i(fstat), .irq_o(irq[1]));
  mc_cfg_regs #(.VARIANT(2)) u_dut_v2 (
    .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we),
    .wdata_i(wd), .rdata_o(rd[2]), .fault_stb_i(stb), .fault_status_i(fstat), .irq_o(irq[2]));

  function automatic logic [31:0] code(int v);
    return 32'(v) << 28;
  endfunction
  function automatic logic [31:0] en_wr(int v, logic [31:0] d);
    return (v == 0) ? (d & 32'h103) : (code(v) | (d & 32'hBFF));
  endfunction
  function automatic logic [31:0] en_keep(int v);
    return (v == 0) ? 32'h100 : 32'hFF00_0BFC;
  endfunction

  task automatic check(string req, int v, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s variant %0d: actual %08h expected %08h", req, v, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wd = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  // combinational read, sampled mid-cycle
  task automatic rd_chk(string req, logic [AW-1:0] a, logic [31:0] e0, logic [31:0] e1, logic [31:0] e2);
    addr = a;
    #1;
    check(req, 0, rd[0], e0);
    check(req, 1, rd[1], e1);
    check(req, 2, rd[2], e2);
  endtask

  task automatic irq_chk(string req, logic exp);
    for (int v = 0; v < 3; v++) check(req, v, 32'(irq[v]), 32'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; addr = '0; we = 1'b0; wd = '0; stb = 1'b0; fstat = '0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);

    // R1 power-on values
    rd_chk("R1 enable", 13'h000, 32'h0, 32'h1000_0000, 32'h2000_0000);
    rd_chk("R1 delay",  13'h004, 32'h20, 32'h20, 32'h20);
    rd_chk("R1 fault",  13'h008, 32'h0, 32'h0, 32'h0);
    rd_chk("R1 video",  13'h00C, 32'h0, 32'h0, 32'h0);
    rd_chk("R1 low address bits", 13'h006, 32'h20, 32'h20, 32'h20);
    irq_chk("R1 irq", 1'b0);

    // R2 R3 enable write masking
    for (int i = 0; i < 40; i++) begin
      logic [31:0] d;
      d = (i < 32) ? (32'h1 << i) : (32'h9E37_79B9 * 32'(i) ^ (32'(i) << 7));
      wr(13'h000, d);
      rd_chk("R2 R3 enable write", 13'h000, en_wr(0, d), en_wr(1, d), en_wr(2, d));
    end
    wr(13'h000, 32'hFFFF_FFFF);
    rd_chk("R2 R3 enable all ones", 13'h003, 32'h103, 32'h1000_0BFF, 32'h2000_0BFF);

    // R13: read mux follows address with no clock edge
    @(negedge clk);
    addr = 13'h004; #0.5;
    check("R13 same-cycle read", 0, rd[0], 32'h20);
    addr = 13'h000; #0.5;
    check("R13 same-cycle read", 1, rd[1], 32'h1000_0BFF);

    // R7 delay / video full width
    for (int i = 0; i < 8; i++) begin
      logic [31:0] a, b;
      a = 32'hC3A5_0F17 ^ (32'h0101_0101 << i);
      b = ~a + 32'(i);
      wr(13'h004, a);
      wr(13'h00C, b);
      rd_chk("R7 delay", 13'h004, a, a, a);
      rd_chk("R7 video", 13'h00C, b, b, b);
    end

    // R4 R5 R6 warm reset retention
    for (int p = 0; p < 3; p++) begin
      logic [31:0] d;
      d = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h5A5A_5A5A : 32'hA5A5_A5A5;
      wr(13'h000, d);
      wr(13'h004, 32'h1234_5678);
      wr(13'h00C, 32'h8765_4321);
      @(negedge clk); stb = 1'b1; fstat = 32'hCAFE_0001;
      @(negedge clk); stb = 1'b0;
      rst_n = 1'b0;
      #1;
      irq_chk("R6 irq drops in warm reset", 1'b0);
      @(negedge clk); rst_n = 1'b1;
      rd_chk("R4 R5 enable retention", 13'h000,
             en_wr(0, d) & en_keep(0), en_wr(1, d) & en_keep(1), en_wr(2, d) & en_keep(2));
      rd_chk("R6 delay", 13'h004, 32'h20, 32'h20, 32'h20);
      rd_chk("R6 fault", 13'h008, 32'h0, 32'h0, 32'h0);
      rd_chk("R6 video", 13'h00C, 32'h0, 32'h0, 32'h0);
    end

    // R8 fault capture
    @(negedge clk); stb = 1'b1; fstat = 32'hDEAD_0042;
    #1;
    irq_chk("R8 irq registered", 1'b0);
    @(negedge clk); stb = 1'b0; fstat = 32'h0;
    irq_chk("R8 irq set", 1'b1);
    rd_chk("R8 status captured", 13'h008, 32'hDEAD_0042, 32'hDEAD_0042, 32'hDEAD_0042);
    repeat (5) @(negedge clk);
    irq_chk("R8 irq held", 1'b1);

    // R9 software clear
    wr(13'h008, 32'h0000_1234);
    #1;
    irq_chk("R9 irq cleared", 1'b0);
    rd_chk("R9 status written", 13'h008, 32'h1234, 32'h1234, 32'h1234);

    // R9 simultaneous strobe and write: strobe wins
    @(negedge clk);
    addr = 13'h008; we = 1'b1; wd = 32'h0BAD_0BAD; stb = 1'b1; fstat = 32'h600D_600D;
    @(negedge clk);
    we = 1'b0; stb = 1'b0;
    #1;
    irq_chk("R9 strobe wins irq", 1'b1);
    rd_chk("R9 strobe wins status", 13'h008, 32'h600D_600D, 32'h600D_600D, 32'h600D_600D);
    wr(13'h008, 32'h0);
    #1;
    irq_chk("R9 irq cleared again", 1'b0);

    // R10 undefined indexes
    wr(13'h000, 32'h0000_0A0F);
    wr(13'h004, 32'h1111_2222);
    wr(13'h00C, 32'h3333_4444);
    for (int k = 4; k < 1024; k++) wr(13'(k << 2), 32'hFFFF_FFFF);
    for (int k = 4; k < 1024; k += 13) rd_chk("R10 undefined reads zero", 13'(k << 2), 32'h0, 32'h0, 32'h0);
    rd_chk("R10 enable untouched", 13'h000, en_wr(0, 32'hA0F), en_wr(1, 32'hA0F), en_wr(2, 32'hA0F));
    rd_chk("R10 delay untouched", 13'h004, 32'h1111_2222, 32'h1111_2222, 32'h1111_2222);
    rd_chk("R10 fault untouched", 13'h008, 32'h0, 32'h0, 32'h0);
    rd_chk("R10 video untouched", 13'h00C, 32'h3333_4444, 32'h3333_4444, 32'h3333_4444);
    irq_chk("R10 irq untouched", 1'b0);

    // R11 R12 diagnostic window
    for (int n = 0; n < 16; n++) wr(13'h1000 + 13'(n), {24'hABCDEF, 8'(n * 37 + 5)});
    for (int n = 16; n < 256; n++) wr(13'h1000 + 13'(n), 32'hFFFF_FFFF);
    for (int n = 0; n < 16; n++)
      rd_chk("R11 R12 diag byte", 13'h1000 + 13'(n), {24'h0, 8'(n * 37 + 5)}, 32'h0, 32'h0);
    for (int n = 16; n < 256; n += 7)
      rd_chk("R11 R12 beyond depth", 13'h1000 + 13'(n), 32'h0, 32'h0, 32'h0);
    rd_chk("R12 enable untouched", 13'h000, en_wr(0, 32'hA0F), en_wr(1, 32'hA0F), en_wr(2, 32'hA0F));
    rd_chk("R12 delay untouched", 13'h004, 32'h1111_2222, 32'h1111_2222, 32'h1111_2222);
    rd_chk("R12 video untouched", 13'h00C, 32'h3333_4444, 32'h3333_4444, 32'h3333_4444);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule